// File: doc/BRIEF.md
# Link-Down Recovery Reset Watchdog

This supervisory block keeps a link from staying dead. It watches a link-status input. While the link stays down and no loopback is active, it counts millisecond ticks. Each time a full interval of ticks passes, it asks the downstream logic for a limited reset. A limited reset clears the operational logic and keeps configuration state. Any cycle in which the link is up, or a loopback is active, restarts the interval count. After each watchdog reset the count also starts over, so repeated resets are one full interval apart.

The same reset sequencer serves two other causes:
- a software request;
- a pulse that marks a real configuration or loopback change.

Callers raise the change pulse only when something actually changed, because every limited reset disturbs the link.

The request output is self-clearing. The block raises it and then checks the reset-done input once every `POLL_GAP` clock cycles, for at most `POLL_LIMIT` checks. The request drops at the first check that finds done high. If no check finds done high, the request drops and a timeout flag is set. While a reset is in flight, any new cause is dropped rather than queued. Each reset that the watchdog starts is marked by a one-cycle pulse, so that these resets can be counted.

Top module: `link_recovery_wd`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `logic_rst_req`, `wd_fire` and `rst_timeout` are all 0.
- R2: With `link_up` and `loopback_on` both low, the watchdog expires on every `INTERVAL_TICKS`-th cycle in which `ms_tick` is high. If the block is idle, that expiry raises `logic_rst_req` one cycle later, together with a `wd_fire` pulse that lasts exactly one cycle.
- R3: Any cycle with `link_up` or `loopback_on` high restarts the tick count. After it, the next expiry needs a further `INTERVAL_TICKS` ticks with both inputs low.
- R4: Every expiry restarts the tick count. While the link stays down, resets therefore repeat every `INTERVAL_TICKS` ticks.
- R5: After a reset starts, `rst_done` is sampled only on every `POLL_GAP`-th cycle. The request clears in the cycle after the first sample that finds `rst_done` high, and `rst_timeout` stays 0.
- R6: If `POLL_LIMIT` samples all find `rst_done` low, `logic_rst_req` drops and `rst_timeout` rises in the same cycle. `rst_timeout` then stays 1 until the next reset starts, which clears it.
- R7: A one-cycle `sw_reset_req` or `cfg_change` pulse while idle raises `logic_rst_req` on the next cycle. It does not raise `wd_fire`.
- R8: A cause that arrives while `logic_rst_req` is high is dropped. This includes the cycle in which the request is clearing. No reset follows once the current one completes.
- R9: If a watchdog expiry and a software or change request fall in the same idle cycle, exactly one reset starts, and `wd_fire` pulses.
- R10: A watchdog expiry during a reset gives no `wd_fire` and no later reset. It still restarts the tick count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle millisecond tick |
| link_up | input | 1 | Link reported up |
| loopback_on | input | 1 | Some loopback mode is active |
| cfg_change | input | 1 | Pulse: configuration or loopback changed |
| sw_reset_req | input | 1 | Pulse: software-triggered limited reset |
| rst_done | input | 1 | Reset completion from the logic being reset |
| logic_rst_req | output | 1 | Self-clearing limited reset request |
| wd_fire | output | 1 | One-cycle marker of a watchdog-started reset |
| rst_timeout | output | 1 | Last reset was not acknowledged within the poll budget |

## Verification
The watchdog expiry can land in the same cycle as a software request, a change pulse, or a reset that is already in flight. The bench provokes each case by choosing the clock edge on which the tick count hits its last value:
- In the idle case (R9), the bench puts a software pulse on that edge. It expects one request rise and one `wd_fire`.
- In the busy case (R10), the bench lets the expiry fall inside a reset that never gets a done. It expects no fire until the following interval.

A behavioural model in the bench, made of integer counters, predicts all three outputs on every clock. Counted rises and fires judge each case.

// File: rtl/lrw_pkg.sv
package lrw_pkg;

  typedef enum logic {SEQ_IDLE, SEQ_WAIT} seq_state_e;

  // Counter width able to hold 0 .. n-1 (at least one bit)
  function automatic int unsigned cnt_w(int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  // True when a counter sits on the last value of a modulo-lim range
  function automatic logic at_last(logic [31:0] value, logic [31:0] lim);
    return value == (lim - 32'd1);
  endfunction

endpackage

// File: rtl/lrw_interval_timer.sv
module lrw_interval_timer #(
  parameter int unsigned INTERVAL_TICKS = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  input  logic hold,
  output logic expiry
);
  localparam int unsigned CW = lrw_pkg::cnt_w(INTERVAL_TICKS);

  logic [CW-1:0] tick_cnt;

  assign expiry = ms_tick & ~hold & lrw_pkg::at_last(32'(tick_cnt), 32'(INTERVAL_TICKS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_cnt <= '0;
    end else if (hold) begin
      tick_cnt <= '0;
    end else if (ms_tick) begin
      if (expiry) tick_cnt <= '0;
      else        tick_cnt <= tick_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/lrw_reset_seq.sv
module lrw_reset_seq #(
  parameter int unsigned POLL_LIMIT = 50,
  parameter int unsigned POLL_GAP   = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic rst_done,
  output logic busy,
  output logic timeout,
  output logic poll_now
);
  localparam int unsigned GW = lrw_pkg::cnt_w(POLL_GAP);
  localparam int unsigned PW = lrw_pkg::cnt_w(POLL_LIMIT);

  lrw_pkg::seq_state_e state;
  logic [GW-1:0] gap_cnt;
  logic [PW-1:0] poll_cnt;
  logic          last_poll;

  assign busy      = (state == lrw_pkg::SEQ_WAIT);
  assign poll_now  = busy & lrw_pkg::at_last(32'(gap_cnt), 32'(POLL_GAP));
  assign last_poll = lrw_pkg::at_last(32'(poll_cnt), 32'(POLL_LIMIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= lrw_pkg::SEQ_IDLE;
      gap_cnt  <= '0;
      poll_cnt <= '0;
      timeout  <= 1'b0;
    end else begin
      case (state)
        lrw_pkg::SEQ_IDLE: begin
          if (start) begin
            state    <= lrw_pkg::SEQ_WAIT;
            gap_cnt  <= '0;
            poll_cnt <= '0;
            timeout  <= 1'b0;
          end
        end
        default: begin
          if (poll_now) begin
            gap_cnt <= '0;
            if (rst_done) begin
              state <= lrw_pkg::SEQ_IDLE;
            end else if (last_poll) begin
              state   <= lrw_pkg::SEQ_IDLE;
              timeout <= 1'b1;
            end else begin
              poll_cnt <= poll_cnt + 1'b1;
            end
          end else begin
            gap_cnt <= gap_cnt + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/link_recovery_wd.sv
module link_recovery_wd #(
  parameter int unsigned INTERVAL_TICKS = 5000,
  parameter int unsigned POLL_LIMIT     = 50,
  parameter int unsigned POLL_GAP       = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  input  logic link_up,
  input  logic loopback_on,
  input  logic cfg_change,
  input  logic sw_reset_req,
  input  logic rst_done,
  output logic logic_rst_req,
  output logic wd_fire,
  output logic rst_timeout
);
  // Named internal events, visible to the bound checker
  logic link_hold;
  logic wd_expiry;
  logic seq_busy;
  logic seq_timeout;
  logic poll_now;
  logic start_any;
  logic wd_accept;
  logic wd_fire_q;

  assign link_hold = link_up | loopback_on;
  assign start_any = (wd_expiry | cfg_change | sw_reset_req) & ~seq_busy;
  assign wd_accept = wd_expiry & ~seq_busy;

  lrw_interval_timer #(.INTERVAL_TICKS(INTERVAL_TICKS)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .ms_tick (ms_tick),
    .hold    (link_hold),
    .expiry  (wd_expiry)
  );

  lrw_reset_seq #(.POLL_LIMIT(POLL_LIMIT), .POLL_GAP(POLL_GAP)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_any),
    .rst_done (rst_done),
    .busy     (seq_busy),
    .timeout  (seq_timeout),
    .poll_now (poll_now)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wd_fire_q <= 1'b0;
    else        wd_fire_q <= wd_accept;
  end

  assign logic_rst_req = seq_busy;
  assign wd_fire       = wd_fire_q;
  assign rst_timeout   = seq_timeout;
endmodule

// File: rtl/lrw_checker.sv
module lrw_checker (
  input logic clk,
  input logic rst_n,
  input logic link_up,
  input logic loopback_on,
  input logic cfg_change,
  input logic sw_reset_req,
  input logic rst_done,
  input logic logic_rst_req,
  input logic wd_fire,
  input logic rst_timeout,
  input logic wd_expiry,
  input logic poll_now
);
  AST_FIRE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wd_fire |=> !wd_fire); // R2
  AST_FIRE_WITH_START: assert property (@(posedge clk) disable iff (!rst_n)
    wd_fire |-> (logic_rst_req && !$past(logic_rst_req))); // R2
  AST_HOLD_BLOCKS_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (link_up || loopback_on) |=> !wd_fire); // R3
  AST_START_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(logic_rst_req) |-> $past(sw_reset_req || cfg_change || wd_expiry)); // R7
  AST_DROP_AT_POLL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(logic_rst_req) |-> $past(poll_now)); // R5
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(logic_rst_req) && !rst_timeout) |-> $past(rst_done)); // R5
  AST_TIMEOUT_WITH_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_timeout) |-> $fell(logic_rst_req)); // R6
endmodule

bind link_recovery_wd lrw_checker u_lrw_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .link_up       (link_up),
  .loopback_on   (loopback_on),
  .cfg_change    (cfg_change),
  .sw_reset_req  (sw_reset_req),
  .rst_done      (rst_done),
  .logic_rst_req (logic_rst_req),
  .wd_fire       (wd_fire),
  .rst_timeout   (rst_timeout),
  .wd_expiry     (wd_expiry),
  .poll_now      (poll_now)
);

// File: tb/tb_link_recovery_wd.sv
`timescale 1ns/1ps
module tb_link_recovery_wd;
  localparam int IVL = 6;
  localparam int LIM = 4;
  localparam int GAP = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ms_tick = 1'b0, link_up = 1'b1, loopback_on = 1'b0;
  logic cfg_change = 1'b0, sw_reset_req = 1'b0, rst_done = 1'b0;
  logic logic_rst_req, wd_fire, rst_timeout;

  int checks = 0, fails = 0;
  int fire_cnt = 0, rise_cnt = 0, req_cyc = 0;
  logic prev_req = 1'b0;

  // behavioural reference state
  int  m_ticks = 0, m_since = 0;
  bit  m_busy = 0, m_to = 0, m_fire = 0;

  always #2 clk = ~clk;

  link_recovery_wd #(.INTERVAL_TICKS(IVL), .POLL_LIMIT(LIM), .POLL_GAP(GAP)) dut (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .link_up(link_up),
    .loopback_on(loopback_on), .cfg_change(cfg_change), .sw_reset_req(sw_reset_req),
    .rst_done(rst_done), .logic_rst_req(logic_rst_req), .wd_fire(wd_fire),
    .rst_timeout(rst_timeout)
  );

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_int(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model: reacts to the inputs present at each rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ticks = 0; m_since = 0; m_busy = 0; m_to = 0; m_fire = 0;
    end else begin
      bit hold, expd, req, nb, nto;
      int nticks, nsince;
      hold   = link_up || loopback_on;
      expd   = ms_tick && !hold && (m_ticks + 1 == IVL);
      req    = expd || sw_reset_req || cfg_change;
      nb = m_busy; nto = m_to; nsince = m_since;
      if (m_busy) begin
        nsince = m_since + 1;
        if (nsince % GAP == 0) begin
          if (rst_done) nb = 0;
          else if (nsince / GAP == LIM) begin nb = 0; nto = 1; end
        end
      end else if (req) begin
        nb = 1; nsince = 0; nto = 0;
      end
      if (hold) nticks = 0;
      else if (ms_tick) nticks = expd ? 0 : m_ticks + 1;
      else nticks = m_ticks;
      m_fire  = expd && !m_busy;
      m_busy  = nb; m_to = nto; m_since = nsince; m_ticks = nticks;
    end
  end

  // Per-cycle comparison and event counting, away from the edge
  always @(posedge clk) begin
    #1;
    check("R5 request vs model", logic_rst_req, m_busy);
    check("R2 fire vs model", wd_fire, m_fire);
    check("R6 timeout vs model", rst_timeout, m_to);
    if (wd_fire) fire_cnt++;
    if (logic_rst_req) req_cyc++;
    if (logic_rst_req && !prev_req) rise_cnt++;
    prev_req = logic_rst_req;
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_timer();
    link_up = 1'b1; ms_tick = 1'b0; step(1);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    int f0, r0, c0;
    step(3);
    check("R1 req in reset", logic_rst_req, 1'b0);
    check("R1 fire in reset", wd_fire, 1'b0);
    check("R1 timeout in reset", rst_timeout, 1'b0);
    rst_n = 1'b1;
    step(1);
    check("R1 req after release", logic_rst_req, 1'b0);
    check("R1 timeout after release", rst_timeout, 1'b0);

    // R2 / R4: repeating expiries with quick acknowledgement
    rst_done = 1'b1; clear_timer();
    f0 = fire_cnt;
    link_up = 1'b0; ms_tick = 1'b1;
    step(10 * IVL);
    ms_tick = 1'b0; step(4);
    check_int("R2 R4 fires over ten intervals", fire_cnt - f0, 10);

    // R3: link-up blip restarts count
    clear_timer(); f0 = fire_cnt;
    link_up = 1'b0; ms_tick = 1'b1; step(IVL - 2);
    link_up = 1'b1; step(1);
    link_up = 1'b0; step(IVL - 1);
    ms_tick = 1'b0; step(2);
    check_int("R3 no fire after link-up restart", fire_cnt - f0, 0);
    ms_tick = 1'b1; step(1); ms_tick = 1'b0; step(2);
    check_int("R3 fire after full interval", fire_cnt - f0, 1);

    // R3: loopback also restarts count
    clear_timer(); f0 = fire_cnt;
    link_up = 1'b0; ms_tick = 1'b1; step(IVL - 1);
    loopback_on = 1'b1; step(1); loopback_on = 1'b0;
    step(IVL - 1); ms_tick = 1'b0; step(2);
    check_int("R3 loopback restart", fire_cnt - f0, 0);
    clear_timer();

    // R5: done seen at second poll
    rst_done = 1'b0; c0 = req_cyc;
    sw_reset_req = 1'b1; step(1); sw_reset_req = 1'b0;
    step(GAP + 1); rst_done = 1'b1;
    step(2 * GAP); rst_done = 1'b0;
    check_int("R5 request held two poll gaps", req_cyc - c0, 2 * GAP);
    check("R5 no timeout on ack", rst_timeout, 1'b0);

    // R6: poll budget exhausted
    c0 = req_cyc;
    sw_reset_req = 1'b1; step(1); sw_reset_req = 1'b0;
    step(LIM * GAP + 2);
    check_int("R6 request length on timeout", req_cyc - c0, LIM * GAP);
    check("R6 timeout flagged", rst_timeout, 1'b1);
    step(3);
    check("R6 timeout sticky", rst_timeout, 1'b1);
    rst_done = 1'b1;
    sw_reset_req = 1'b1; step(1); sw_reset_req = 1'b0;
    check("R6 timeout cleared on new start", rst_timeout, 1'b0);
    step(GAP + 2);

    // R7: change pulse starts reset without fire
    r0 = rise_cnt; f0 = fire_cnt;
    cfg_change = 1'b1; step(1); cfg_change = 1'b0;
    check("R7 request raised by change", logic_rst_req, 1'b1);
    step(GAP + 2);
    check_int("R7 one rise", rise_cnt - r0, 1);
    check_int("R7 no fire", fire_cnt - f0, 0);

    // R8: causes during a busy reset are dropped
    rst_done = 1'b0; r0 = rise_cnt;
    sw_reset_req = 1'b1; step(1); sw_reset_req = 1'b0;
    step(3); cfg_change = 1'b1; sw_reset_req = 1'b1; step(1);
    cfg_change = 1'b0; sw_reset_req = 1'b0;
    step(LIM * GAP + 6);
    check_int("R8 single reset", rise_cnt - r0, 1);
    check("R8 idle afterwards", logic_rst_req, 1'b0);

    // R9: expiry and software request together
    rst_done = 1'b1; clear_timer(); r0 = rise_cnt; f0 = fire_cnt;
    link_up = 1'b0; ms_tick = 1'b1;
    for (int i = 0; i < IVL; i++) begin
      if (i == IVL - 1) sw_reset_req = 1'b1;
      step(1);
    end
    sw_reset_req = 1'b0; ms_tick = 1'b0; link_up = 1'b1;
    check("R9 fire with coincident request", wd_fire, 1'b1);
    step(GAP + 2);
    check_int("R9 one reset", rise_cnt - r0, 1);
    check_int("R9 one fire", fire_cnt - f0, 1);

    // R10: expiry during a busy reset is dropped but restarts count
    clear_timer(); rst_done = 1'b0; f0 = fire_cnt; r0 = rise_cnt;
    link_up = 1'b0;
    sw_reset_req = 1'b1; step(1); sw_reset_req = 1'b0;
    ms_tick = 1'b1; step(2 * IVL);
    check_int("R10 expiries in busy dropped", fire_cnt - f0, 0);
    rst_done = 1'b1;
    step(IVL); ms_tick = 1'b0; link_up = 1'b1; step(GAP + 2);
    check_int("R10 next interval fires", fire_cnt - f0, 1);
    check_int("R10 two resets total", rise_cnt - r0, 2);

    finish_run();
  end
endmodule